// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

A free-running time base that keeps 64 bits of whole nanoseconds plus a 32-bit sub-nanosecond remainder. On every enabled cycle of the datapath clock it adds a programmable fixed-point step (32 integer bits, 32 fractional bits). The carry out of the fractional sum moves into the nanosecond count, so a step that is not a whole number of nanoseconds is tracked accurately over time. The count is 64 bits wide and never needs wrap handling. Any logic that captures timestamps can use the integer time directly on `time_ns`.

Software reaches the counter through a 32-bit register port. The time and the step are each split into a low and a high word. Reading the low time word freezes the upper half in a snapshot, and the next high read returns that snapshot. Writing a low word only stages the value. The full 64-bit time or step takes effect when the matching high word is written. Frequency trimming and step selection for each link speed are computed elsewhere. Only the resulting step is written into this block.

Register map (word address on `addr`): 0 control (bit 0 = run), 1 time low, 2 time high, 3 step low, 4 step high.

Top module: `ns_time_counter`

## Requirements
- R1: After reset, the time, the fractional remainder, the step and the run bit are all zero, and reads of addresses 0 to 4 return zero.
- R2: While run is set, each cycle adds the step's integer part plus the carry of the 32-bit fractional sum to the time. N cycles after a load of T, the time equals T + floor(N*step/2^32).
- R3: A read of address 1 returns the live low 32 bits of time and snapshots the upper 32 bits in the same cycle. A later read of address 2 returns that snapshot, even if the live upper half has since moved on.
- R4: A write to address 1 only stages a value and leaves the time unchanged. A write to address 2 loads {written word, staged low word} into the time and clears the fractional remainder.
- R5: In the cycle a time load commits, the loaded value wins over the step. In the next cycle the time equals exactly the written 64-bit value, even while running.
- R6: A write to address 3 only stages the step low word, and the previous step stays in use. A write to address 4 commits {written word, staged low word}. Addresses 3 and 4 read back the committed step.
- R7: A step of zero keeps the time constant while run is set.
- R8: Bit 0 of address 0 is the run bit and reads back at bit 0. With it clear, the time holds, and it can still be read and loaded.
- R9: A carry out of the low 32 bits of time propagates into the upper half.
- R10: `rdata` is valid in the same cycle as the read and decodes `addr` combinationally. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock; one count step per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers the time snapshot on address 1) |
| addr | input | AW (3) | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| time_ns | output | 64 | Current integer nanosecond time |

## Verification
The counting path is tried with several steps. A step just under 1.6 ns exposes truncation of the fractional sum. A 3.2 ns step accumulates carries over many cycles, and a whole 32 ns step has no fraction at all. A step of zero separates "halted" from "disabled". Loads placed just below a 32-bit boundary, followed by a split read, separate a true snapshot from a live read of the upper word and show that the carry crosses into the high half. Writing only low words, both for the time and for the step, shows whether a half-written value leaks into the count before its high word arrives.

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [63:0]   time_ns
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_TLO  = AW'(1);
  localparam logic [AW-1:0] A_THI  = AW'(2);
  localparam logic [AW-1:0] A_SLO  = AW'(3);
  localparam logic [AW-1:0] A_SHI  = AW'(4);

  logic        run_q;
  logic [63:0] now_q;
  logic [63:0] step_q;
  logic [31:0] frac_q;
  logic [31:0] tlo_stage, slo_stage, snap_hi;

  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire wr_tlo  = wr_en && (addr == A_TLO);
  wire wr_thi  = wr_en && (addr == A_THI);
  wire wr_slo  = wr_en && (addr == A_SLO);
  wire wr_shi  = wr_en && (addr == A_SHI);
  wire rd_tlo  = rd_en && (addr == A_TLO);

  wire [32:0] frac_sum = {1'b0, frac_q} + {1'b0, step_q[31:0]};
  wire [63:0] now_nxt  = now_q + {32'd0, step_q[63:32]} + {63'd0, frac_sum[32]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      now_q     <= '0;
      step_q    <= '0;
      frac_q    <= '0;
      tlo_stage <= '0;
      slo_stage <= '0;
      snap_hi   <= '0;
    end else begin
      if (wr_ctrl) run_q     <= wdata[0];
      if (wr_tlo)  tlo_stage <= wdata;
      if (wr_slo)  slo_stage <= wdata;
      if (wr_shi)  step_q    <= {wdata, slo_stage};
      if (rd_tlo)  snap_hi   <= now_q[63:32];
      if (wr_thi) begin
        now_q  <= {wdata, tlo_stage};
        frac_q <= '0;
      end else if (run_q) begin
        now_q  <= now_nxt;
        frac_q <= frac_sum[31:0];
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {31'd0, run_q};
      A_TLO:   rdata = now_q[31:0];
      A_THI:   rdata = snap_hi;
      A_SLO:   rdata = step_q[31:0];
      A_SHI:   rdata = step_q[63:32];
      default: rdata = '0;
    endcase
  end

  assign time_ns = now_q;
endmodule

// File: rtl/ns_time_counter_chk.sv
module ns_time_counter_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic [63:0]   time_ns,
  input logic          run
);
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> time_ns[63:32] == $past(wdata));

  a_r4_low_staged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1) && !run) |=> $stable(time_ns));

  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && addr == AW'(2))) |=> $stable(time_ns));

  a_r2_never_backwards: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(wr_en && addr == AW'(2))) |=> time_ns >= $past(time_ns));

  a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en && addr == AW'(1)) && addr == AW'(2)) |-> rdata == $past(time_ns[63:32]));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > AW'(4)) |-> rdata == 32'd0);
endmodule

bind ns_time_counter ns_time_counter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .time_ns(time_ns), .run(run_q)
);

// File: tb/ns_time_counter_test.sv
module ns_time_counter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_ns;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ns_time_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .time_ns(time_ns)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read is on the port
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rd_en && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {32'd0, rdata}, {32'd0, e});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rate(input logic [63:0] t0, input logic [63:0] stp, input int n, input string tag);
    logic [63:0] adv;
    wr(3'd3, stp[31:0]);
    wr(3'd4, stp[63:32]);
    wr(3'd1, t0[31:0]);
    wr(3'd2, t0[63:32]);
    chk({tag, " R5 load exact"}, time_ns, t0);
    idle(n);
    adv = (64'(n) * stp) >> 32;
    chk({tag, " count"}, time_ns, t0 + adv);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 time after reset", time_ns, 64'd0);
    rd(3'd0, 32'd0, "R1 ctrl");
    rd(3'd1, 32'd0, "R1 time lo");
    rd(3'd2, 32'd0, "R1 time hi");
    rd(3'd3, 32'd0, "R1 step lo");
    rd(3'd4, 32'd0, "R1 step hi");
    rd(3'd5, 32'd0, "R10 addr5");
    rd(3'd7, 32'd0, "R10 addr7");

    // run bit clear: step programmed, time must not move
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd1);
    rd(3'd4, 32'd1, "R6 step hi readback");
    idle(5);
    chk("R8 hold while off", time_ns, 64'd0);

    // staged time low write
    wr(3'd1, 32'h0000_1234);
    chk("R4 low write staged", time_ns, 64'd0);
    wr(3'd2, 32'h0000_0007);
    chk("R4 high write commits", time_ns, 64'h7_0000_1234);
    rd(3'd1, 32'h0000_1234, "R8 readable while off");

    wr(3'd0, 32'd1);
    rd(3'd0, 32'd1, "R8 ctrl readback");

    rate(64'd100, 64'h1_9999_9999, 10, "R2 1.6ns");
    rate(64'd0, 64'h3_3333_3333, 25, "R2 3.2ns");
    rate(64'd5, 64'h20_0000_0000, 7, "R2 32ns");
    rate(64'h1_FFFF_FFC0, 64'h20_0000_0000, 4, "R9 carry into hi");
    rate(64'h55, 64'd0, 20, "R7 zero step");

    // split read across a 32-bit boundary
    rate(64'h5_FFFF_FFF0, 64'h10_0000_0000, 0, "R3 setup");
    rd(3'd1, 32'hFFFF_FFF0, "R3 low read live");
    idle(3);
    chk("R9 live hi moved", {32'd0, time_ns[63:32]}, 64'd6);
    rd(3'd2, 32'd5, "R3 snapshot hi");

    // staged step low word must not change the rate
    rate(64'd0, 64'h1_0000_0000, 0, "R6 setup");
    wr(3'd3, 32'hFFFF_FFFF);
    idle(3);
    chk("R6 old step still used", time_ns, 64'd4);
    rd(3'd3, 32'd0, "R6 committed lo unchanged");

    // stop and load while off
    wr(3'd0, 32'd0);
    held = time_ns;
    idle(5);
    chk("R8 holds after stop", time_ns, held);
    wr(3'd1, 32'd9);
    wr(3'd2, 32'd0);
    chk("R8 load while off", time_ns, 64'd9);
    rd(3'd0, 32'd0, "R8 ctrl cleared");

    idle(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule